// File: doc/BRIEF.md
# Event Latch Status Register with Selectable Clearing

This block holds a bank of sticky status flags, one per raw event line, together with a matching bank of interrupt enables. A flag is captured on an event edge and stays captured until host software removes it. The host can remove flags in one of two ways, chosen by a global mode input. In clear-on-write mode it writes ones to the positions it wants removed. In clear-on-read mode the act of reading removes them, and the scope of that read follows the bus width in use. An interrupt request is raised while any captured flag has its enable set.

Each bit can be configured to capture only when its event becomes active, or to capture on every change of its event. After a flag is removed, it cannot be captured again while the event stays active; the event has to drop and return first. Some bit positions are reserved, and events can never set them. A data-path reset input empties the flag bank and blocks writes to the enables while it is held low. Address decoding is outside the block: a single select input chooses between the flag bank and the enable bank.

Top module: `evt_latch_stat`

## Requirements
- R1: A flag bit becomes 1 on the clock edge at which its event is sampled 1 after having been sampled 0 at the previous edge. It then stays 1 until a clear removes it. The previous-sample reference is 0 out of reset.
- R2: While an event stays at 1, a cleared flag stays 0. Only a new 0-to-1 transition of the event sets the flag again.
- R3: When a bit's change-mode input is 1, the flag is also set on a 1-to-0 transition of its event. When the change-mode input is 0, a 1-to-0 transition has no effect.
- R4: With clr_on_wr=1, a write to the flag bank (host_sel=0) clears exactly the positions written as 1 and leaves the others unchanged. In this mode reads clear nothing.
- R5: With clr_on_wr=0 and wide_bus=1, a read of the flag bank returns all 16 flags and then clears all of them.
- R6: With clr_on_wr=0 and wide_bus=0, a read of the flag bank returns only the addressed byte (host_byte=0 selects bits 7:0, host_byte=1 selects bits 15:8) in host_rdata[7:0], with the upper bits zero. The read clears only that byte.
- R7: With clr_on_wr=0, writes to the flag bank have no effect.
- R8: The enable bank (host_sel=1) reads back what was written. A wide write sets all 16 bits. A byte write (wide_bus=0) places host_wdata[7:0] into the addressed byte and leaves the other byte unchanged.
- R9: irq is registered. It is 1 on the cycle after one in which any flag bit and its enable bit are both 1, and 0 otherwise. Enables of reserved positions count the same as the others.
- R10: Reserved positions (RSVD_MASK, default bits 15 and 14) never read as 1 in the flag bank, whatever their events do.
- R11: If a set event and a clear hit the same flag on the same edge, the flag ends up 1.
- R12: While dp_rst_n is 0, every flag is cleared and writes to the enable bank are ignored.
- R13: host_rdata is updated on the clock edge at which host_rd is sampled 1. It holds the value from before any clear caused by that read, and it keeps that value until the next read. It is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dp_rst_n | input | 1 | Synchronous active-low data-path reset |
| evt_raw | input | 16 | Raw event levels, one per flag |
| chg_mode | input | 16 | Per-bit capture-on-any-change enable |
| clr_on_wr | input | 1 | 1: clear by writing ones, 0: clear by reading |
| wide_bus | input | 1 | 1: 16-bit host access, 0: byte access |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_sel | input | 1 | 0: flag bank, 1: enable bank |
| host_byte | input | 1 | Byte lane for byte access |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Single-cycle event pulses show that a flag latches and then holds after its event drops. An event held high across a clear shows that re-arming needs a fresh rising edge. Paired rising and falling edges, run once with change mode on and once with it off, separate capture on both edges from capture on the rising edge only. In each clearing mode, reads and writes are issued with multi-bit patterns such as 0209h and 1001h: a partial write mask tells clear-on-write apart from a full clear, and reading one byte and then the whole register shows that a byte read leaves the other byte untouched. A clear issued in the same cycle as a rising edge, a pulse on a reserved position with its enable set, and a data-path reset with an enable write held against it cover the priority and masking corners.

// File: rtl/els_pkg.sv
package els_pkg;

  typedef enum logic {
    CLR_ON_READ  = 1'b0,
    CLR_ON_WRITE = 1'b1
  } clr_mode_e;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic     rd;
    logic     wr;
    logic     wide;
    reg_sel_e sel;
  } host_op_t;

endpackage

// File: rtl/els_edge_det.sv
module els_edge_det #(
  parameter int              WIDTH     = 16,
  parameter logic [WIDTH-1:0] RSVD_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] evt,
  input  logic [WIDTH-1:0] chg_mode,
  output logic [WIDTH-1:0] set_vec
);

  logic [WIDTH-1:0] evt_q;
  logic [WIDTH-1:0] evt_d;

  always_comb evt_d = evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (RSVD_MASK[i]) begin : g_rsvd
      always_comb set_vec[i] = 1'b0;
    end else begin : g_live
      logic rise, fall;
      always_comb begin
        rise       = evt[i] & ~evt_q[i];
        fall       = ~evt[i] & evt_q[i];
        set_vec[i] = rise | (chg_mode[i] & fall);
      end
    end
  end

endmodule

// File: rtl/els_clr_gen.sv
module els_clr_gen
  import els_pkg::*;
#(
  parameter int WIDTH  = 16,
  parameter int NBYTES = WIDTH / 8,
  parameter int BSEL_W = 1
) (
  input  host_op_t           op,
  input  clr_mode_e          mode,
  input  logic [BSEL_W-1:0]  byte_idx,
  input  logic [WIDTH-1:0]   wdata,
  output logic [WIDTH-1:0]   lane_mask,
  output logic [WIDTH-1:0]   lane_wdata,
  output logic [WIDTH-1:0]   clr_vec
);

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    always_comb begin
      lane_mask[b*8 +: 8]  = (op.wide || (byte_idx == BSEL_W'(b))) ? 8'hFF : 8'h00;
      lane_wdata[b*8 +: 8] = op.wide ? wdata[b*8 +: 8] : wdata[7:0];
    end
  end

  always_comb begin
    clr_vec = '0;
    if (op.sel == SEL_STATUS) begin
      if (mode == CLR_ON_WRITE && op.wr)     clr_vec = lane_wdata & lane_mask;
      else if (mode == CLR_ON_READ && op.rd) clr_vec = lane_mask;
    end
  end

endmodule

// File: rtl/els_lat_bank.sv
module els_lat_bank #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dp_rst_n,
  input  logic [WIDTH-1:0] set_vec,
  input  logic [WIDTH-1:0] clr_vec,
  output logic [WIDTH-1:0] lat_q
);

  logic [WIDTH-1:0] lat_d;
  logic             lat_en;

  always_comb begin
    lat_en = ~dp_rst_n | (|set_vec) | (|clr_vec);
    if (!dp_rst_n) lat_d = '0;
    else           lat_d = (lat_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

endmodule

// File: rtl/els_irq_reg.sv
module els_irq_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] lat,
  input  logic [WIDTH-1:0] ie,
  output logic             irq
);

  logic any_d;

  always_comb any_d = |(lat & ie);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= any_d;
  end

endmodule

// File: rtl/evt_latch_stat.sv
module evt_latch_stat
  import els_pkg::*;
#(
  parameter int               WIDTH     = 16,
  parameter logic [WIDTH-1:0] RSVD_MASK = 16'hC000,
  localparam int              NBYTES    = WIDTH / 8,
  localparam int              BSEL_W    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dp_rst_n,
  input  logic [WIDTH-1:0]  evt_raw,
  input  logic [WIDTH-1:0]  chg_mode,
  input  logic              clr_on_wr,
  input  logic              wide_bus,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [BSEL_W-1:0] host_byte,
  input  logic [WIDTH-1:0]  host_wdata,
  output logic [WIDTH-1:0]  host_rdata,
  output logic              irq
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  always_comb rst_sync_n = rst_sync[SYNC_STAGES-1];

  host_op_t         op;
  clr_mode_e        mode;
  logic [WIDTH-1:0] set_vec, clr_vec, lane_mask, lane_wdata;
  logic [WIDTH-1:0] lat_q, ie_q, ie_d;
  logic             ie_en;
  logic [WIDTH-1:0] rd_full, rdata_d;
  logic [7:0]       rd_byte;

  always_comb begin
    op.rd   = host_rd;
    op.wr   = host_wr;
    op.wide = wide_bus;
    op.sel  = reg_sel_e'(host_sel);
    mode    = clr_mode_e'(clr_on_wr);
  end

  els_edge_det #(.WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK)) u_edge (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt      (evt_raw),
    .chg_mode (chg_mode),
    .set_vec  (set_vec)
  );

  els_clr_gen #(.WIDTH(WIDTH), .NBYTES(NBYTES), .BSEL_W(BSEL_W)) u_clr (
    .op         (op),
    .mode       (mode),
    .byte_idx   (host_byte),
    .wdata      (host_wdata),
    .lane_mask  (lane_mask),
    .lane_wdata (lane_wdata),
    .clr_vec    (clr_vec)
  );

  els_lat_bank #(.WIDTH(WIDTH)) u_lat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .dp_rst_n (dp_rst_n),
    .set_vec  (set_vec),
    .clr_vec  (clr_vec),
    .lat_q    (lat_q)
  );

  // Enable bank: byte-lane write, blocked during data-path reset
  always_comb begin
    ie_en = op.wr && (op.sel == SEL_ENABLE) && dp_rst_n;
    ie_d  = (ie_q & ~lane_mask) | (lane_wdata & lane_mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) ie_q <= '0;
    else if (ie_en)  ie_q <= ie_d;
  end

  // Read path: capture before any clear takes effect
  always_comb begin
    rd_full = (op.sel == SEL_ENABLE) ? ie_q : lat_q;
    rd_byte = '0;
    for (int b = 0; b < NBYTES; b++) begin
      if (host_byte == BSEL_W'(b)) rd_byte = rd_full[b*8 +: 8];
    end
    rdata_d = op.wide ? rd_full : WIDTH'(rd_byte);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) host_rdata <= '0;
    else if (op.rd)  host_rdata <= rdata_d;
  end

  els_irq_reg #(.WIDTH(WIDTH)) u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .lat   (lat_q),
    .ie    (ie_q),
    .irq   (irq)
  );

endmodule

// File: rtl/evt_latch_stat_chk.sv
module evt_latch_stat_chk #(
  parameter int               WIDTH     = 16,
  parameter logic [WIDTH-1:0] RSVD_MASK = 16'hC000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dp_rst_n,
  input logic [WIDTH-1:0] evt_raw,
  input logic             clr_on_wr,
  input logic             host_rd,
  input logic             host_wr,
  input logic [WIDTH-1:0] host_rdata,
  input logic             irq,
  input logic [WIDTH-1:0] lat,
  input logic [WIDTH-1:0] ie
);

  logic [WIDTH-1:0] prev_evt;
  logic [WIDTH-1:0] rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_evt <= '0;
    else        prev_evt <= evt_raw;
  end
  always_comb rise = evt_raw & ~prev_evt & ~RSVD_MASK;

  // R1 and R11: a rising edge always leaves its flag set, even against a clear
  assert_rise_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rst_n && (rise != '0)) |=> ((lat & $past(rise)) == $past(rise)));

  // R1: with no access and no event change, flags hold
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rst_n && !host_rd && !host_wr && (evt_raw == prev_evt)) |=> $stable(lat));

  // R4: in clear-on-write mode no flag drops without a write
  assert_cow_no_read_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dp_rst_n && clr_on_wr && !host_wr) |=> ((lat & $past(lat)) == $past(lat)));

  // R9: registered interrupt follows enabled flags
  assert_irq_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past(|(lat & ie)));

  // R10: reserved positions stay clear
  assert_rsvd_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (lat & RSVD_MASK) == '0);

  // R12: data-path reset empties flags and freezes enables
  assert_dprst_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_rst_n |=> (lat == '0));
  assert_dprst_ie_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dp_rst_n |=> $stable(ie));

  // R13: read data only moves on a read
  assert_rdata_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

endmodule

bind evt_latch_stat evt_latch_stat_chk #(.WIDTH(WIDTH), .RSVD_MASK(RSVD_MASK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .dp_rst_n   (dp_rst_n),
  .evt_raw    (evt_raw),
  .clr_on_wr  (clr_on_wr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_rdata (host_rdata),
  .irq        (irq),
  .lat        (lat_q),
  .ie         (ie_q)
);

// File: tb/evt_latch_stat_tb.sv
`timescale 1ns/1ps
module evt_latch_stat_tb;

  logic        clk = 1'b0;
  logic        rst_n, dp_rst_n;
  logic [15:0] evt_raw, chg_mode, host_wdata;
  logic        clr_on_wr, wide_bus, host_rd, host_wr, host_sel;
  logic [0:0]  host_byte;
  logic [15:0] host_rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic        rd_d;

  always #4 clk = ~clk;

  evt_latch_stat u_dut (
    .clk(clk), .rst_n(rst_n), .dp_rst_n(dp_rst_n), .evt_raw(evt_raw),
    .chg_mode(chg_mode), .clr_on_wr(clr_on_wr), .wide_bus(wide_bus),
    .host_rd(host_rd), .host_wr(host_wr), .host_sel(host_sel),
    .host_byte(host_byte), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the expected value of each read one cycle after the strobe
  always @(posedge clk) rd_d <= host_rd;
  always @(negedge clk) begin
    if (rd_d === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard underflow", host_rdata, 16'h0);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(host_rdata === e, t, host_rdata, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_read(input logic sel, input logic b, input logic [15:0] e, input string t);
    host_sel = sel; host_byte = b; host_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic do_write(input logic sel, input logic b, input logic [15:0] d);
    host_sel = sel; host_byte = b; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] m);
    evt_raw = evt_raw | m;
    tick(1);
    evt_raw = evt_raw & ~m;
    tick(1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; dp_rst_n = 1'b1; evt_raw = '0; chg_mode = '0;
    clr_on_wr = 1'b1; wide_bus = 1'b1; host_rd = 1'b0; host_wr = 1'b0;
    host_sel = 1'b0; host_byte = 1'b0; host_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // Reset state (R13, R9)
    check(host_rdata === 16'h0, "R13 reset rdata", host_rdata, 16'h0);
    check(irq === 1'b0, "R9 reset irq", {15'h0, irq}, 16'h0);
    do_read(0, 0, 16'h0000, "R1 reset flags");
    do_read(1, 0, 16'h0000, "R8 reset enables");

    // R1 latch and hold; R4 read does not clear
    pulse(16'h0001);
    do_read(0, 0, 16'h0001, "R1 latched");
    do_read(0, 0, 16'h0001, "R4 read leaves flag");

    // R4 clear-on-write masks
    do_write(0, 0, 16'h0001);
    do_read(0, 0, 16'h0000, "R4 write one clears");
    pulse(16'h0209);
    do_write(0, 0, 16'h0008);
    do_read(0, 0, 16'h0201, "R4 partial clear");
    do_write(0, 0, 16'hFFFF);
    do_read(0, 0, 16'h0000, "R4 full clear");

    // R13 hold without a read
    tick(3);
    check(host_rdata === 16'h0000, "R13 hold", host_rdata, 16'h0000);

    // R2 re-arm only after event drops
    evt_raw[1] = 1'b1; tick(2);
    do_read(0, 0, 16'h0002, "R2 first set");
    do_write(0, 0, 16'h0002);
    tick(3);
    do_read(0, 0, 16'h0000, "R2 no re-set while active");
    evt_raw[1] = 1'b0; tick(1);
    evt_raw[1] = 1'b1; tick(1);
    do_read(0, 0, 16'h0002, "R2 re-set after new edge");
    evt_raw[1] = 1'b0; tick(1);
    do_write(0, 0, 16'hFFFF);

    // R3 change mode
    chg_mode[4] = 1'b1;
    evt_raw[4] = 1'b1; tick(1);
    do_read(0, 0, 16'h0010, "R3 rise");
    do_write(0, 0, 16'h0010);
    evt_raw[4] = 1'b0; tick(1);
    do_read(0, 0, 16'h0010, "R3 fall sets in change mode");
    do_write(0, 0, 16'hFFFF);
    evt_raw[5] = 1'b1; tick(1);
    do_write(0, 0, 16'h0020);
    evt_raw[5] = 1'b0; tick(1);
    do_read(0, 0, 16'h0000, "R3 fall ignored in normal mode");
    chg_mode = '0;

    // R11 set wins over same-cycle clear
    pulse(16'h0040);
    evt_raw[6] = 1'b1;
    do_write(0, 0, 16'h0040);
    do_read(0, 0, 16'h0040, "R11 set wins");
    evt_raw[6] = 1'b0; tick(1);
    do_write(0, 0, 16'hFFFF);

    // R9 interrupt
    do_write(1, 0, 16'h0001);
    pulse(16'h0001);
    check(irq === 1'b1, "R9 irq on", {15'h0, irq}, 16'h1);
    do_write(0, 0, 16'h0001);
    tick(1);
    check(irq === 1'b0, "R9 irq off", {15'h0, irq}, 16'h0);
    pulse(16'h0004);
    tick(1);
    check(irq === 1'b0, "R9 not enabled", {15'h0, irq}, 16'h0);
    do_write(0, 0, 16'hFFFF);

    // R8 byte writes to enables
    wide_bus = 1'b0;
    do_write(1, 1, 16'h00A5);
    do_read(1, 1, 16'h00A5, "R8 byte1 read");
    do_read(1, 0, 16'h0001, "R8 byte0 kept");
    wide_bus = 1'b1;
    do_read(1, 0, 16'hA501, "R8 wide read");

    // R10 reserved bit with its enable set
    pulse(16'h8000);
    tick(1);
    check(irq === 1'b0, "R10 reserved no irq", {15'h0, irq}, 16'h0);
    do_read(0, 0, 16'h0000, "R10 reserved reads zero");
    do_write(1, 0, 16'h0001);

    // R5 clear-on-read, wide
    clr_on_wr = 1'b0;
    pulse(16'h1001);
    do_read(0, 0, 16'h1001, "R5 read returns all");
    do_read(0, 0, 16'h0000, "R5 read cleared all");

    // R6 clear-on-read, byte
    pulse(16'h1001);
    wide_bus = 1'b0;
    do_read(0, 1, 16'h0010, "R6 upper byte");
    wide_bus = 1'b1;
    do_read(0, 0, 16'h0001, "R6 lower byte kept");
    pulse(16'h1001);
    wide_bus = 1'b0;
    do_read(0, 0, 16'h0001, "R6 lower byte");
    wide_bus = 1'b1;
    do_read(0, 0, 16'h1000, "R6 upper byte kept");

    // R7 writes ignored in clear-on-read
    pulse(16'h0004);
    do_write(0, 0, 16'hFFFF);
    do_read(0, 0, 16'h0004, "R7 write ignored");
    do_read(0, 0, 16'h0000, "R7 then read clears");

    // R12 data-path reset
    clr_on_wr = 1'b1;
    pulse(16'h0101);
    dp_rst_n = 1'b0;
    do_write(1, 0, 16'hFFFF);
    dp_rst_n = 1'b1;
    tick(1);
    do_read(0, 0, 16'h0000, "R12 flags cleared");
    do_read(1, 0, 16'h0001, "R12 enable write ignored");

    tick(3);
    check(exp_q.size() == 0, "scoreboard drained", 16'(exp_q.size()), 16'h0);
    done = 1;
    finish_run();
  end

endmodule